// File: doc/BRIEF.md
# Instruction-Cycle Prescaler with Per-Consumer Taps

This block turns the system clock into a slower time base for the timers, the serial shifter, the converter sequencer and a clock-output pin. A phase counter divides the system clock by six to form the instruction-cycle tick. A shared binary counter advances once per tick. Each consumer picks its own power-of-two division from that one counter through a 4-bit ratio code.

Each consumer receives a one-clock enable pulse on the system clock. It never receives a derived clock. Code k (1 to 12) divides the instruction tick by 2^k. The ratio codes are static configuration inputs. The second timer can take its pulses from an external count input instead of the prescaler, and the clock-output pin is a toggle flop clocked by its own tap. The timers and peripherals that use these pulses are outside the block.

Top module: `psc_top`

## Requirements
- R1: While rst_ni is low, every output is 0. The phase counter and the tap counter clear.
- R2: instr_tick_o is a one-clock pulse every 6 system clocks. Its first high cycle follows the 6th rising edge after reset release.
- R3: A ratio code k in 1..12 (hex 1..C) makes the consumer pulse every 6*2^k clocks. The first pulse follows rising edge 6*2^k after reset release. Code 1 is 1/2 and code 12 is 1/4096 of the tick.
- R4: Ratio codes 0, 13, 14 and 15 are illegal. A consumer set to an illegal code never pulses.
- R5: All consumers share one counter. Every pulse of a coarser tap lands in the same cycle as a pulse of any finer tap.
- R6: With timer2_ext_sel_i high, timer2_tick_o gives exactly one pulse per rising edge of timer2_ext_i and ignores its internal tap. The external input is assumed no faster than the system clock / 64.
- R7: clkout_o starts at 0 and toggles in each cycle where its tap pulses, giving a 50% duty square wave of period 12*2^k clocks. With an illegal code it stays 0.
- R8: Every tick output is high for exactly one clock at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (oscillator) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| timer1_code_i | input | 4 | Ratio code for timer 1 |
| timer2_code_i | input | 4 | Ratio code for timer 2 |
| shift_code_i | input | 4 | Ratio code for the serial internal shift clock |
| conv_code_i | input | 4 | Ratio code for the converter control clock |
| clkout_code_i | input | 4 | Ratio code for the clock-output pin |
| timer2_ext_sel_i | input | 1 | 1: timer 2 counts external edges |
| timer2_ext_i | input | 1 | External count input for timer 2 (asynchronous) |
| instr_tick_o | output | 1 | Instruction-cycle enable pulse |
| timer1_tick_o | output | 1 | Timer 1 enable pulse |
| timer2_tick_o | output | 1 | Timer 2 enable pulse |
| shift_tick_o | output | 1 | Serial shift enable pulse |
| conv_tick_o | output | 1 | Converter control enable pulse |
| clkout_o | output | 1 | Square-wave clock output |

## Verification
The coarser and finer taps come from the same counter wrap, so their pulses can fall in the same cycle. The clock-output toggle falls in the same cycle as its own tap pulse. The bench sets timer 1 to the finest code and the converter to a coarser one. It then checks that every converter pulse coincides with a timer 1 pulse, and that the number of converter pulses matches the elapsed clocks. For the clock output, the bench confirms that each edge of the square wave arrives exactly at the clock where the tap would pulse.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int TAPS   = 12;
  localparam int DIV    = 6;
  localparam int N_CONS = 5;
  typedef logic [3:0] code_t;
  typedef enum int {C_TIMER1 = 0, C_TIMER2 = 1, C_SHIFT = 2, C_CONV = 3, C_CLKOUT = 4} cons_e;
endpackage

// File: rtl/psc_base.sv
module psc_base #(
  parameter int DIV   = 6,
  parameter int CNT_W = 12,
  localparam int PH_W = $clog2(DIV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             base_tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PH_W-1:0] phase_q;

  assign base_tick_o = (phase_q == PH_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      cnt_o   <= '0;
    end else begin
      phase_q <= base_tick_o ? '0 : phase_q + 1'b1;
      if (base_tick_o) cnt_o <= cnt_o + 1'b1;
    end
  end

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_tick_o |=> !base_tick_o);
  a_r2_cnt_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_o) |-> $past(base_tick_o));
endmodule

// File: rtl/psc_tap.sv
module psc_tap #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [3:0]       code_i,
  output logic             pulse_o
);
  logic             legal;
  logic [CNT_W-1:0] mask;
  logic             wrap;

  assign legal = (code_i != 4'd0) && (32'(code_i) <= CNT_W);

  // low `code` bits of the counter about to wrap
  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (32'(code_i) > i);
  end
  assign wrap = &(cnt_i | ~mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= base_tick_i & legal & wrap;
  end

  a_r4_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal && $stable(code_i) |=> !pulse_o);
  a_r3_pulse_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(base_tick_i));
  a_r8_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/psc_edge.sv
module psc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      rise_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], async_i};
      rise_o <= sync_q[1] & ~sync_q[2];
    end
  end

  a_r6_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/psc_top.sv
module psc_top #(
  parameter int DIV  = psc_pkg::DIV,
  parameter int TAPS = psc_pkg::TAPS
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] timer1_code_i,
  input  logic [3:0] timer2_code_i,
  input  logic [3:0] shift_code_i,
  input  logic [3:0] conv_code_i,
  input  logic [3:0] clkout_code_i,
  input  logic       timer2_ext_sel_i,
  input  logic       timer2_ext_i,
  output logic       instr_tick_o,
  output logic       timer1_tick_o,
  output logic       timer2_tick_o,
  output logic       shift_tick_o,
  output logic       conv_tick_o,
  output logic       clkout_o
);
  import psc_pkg::*;

  logic                base_tick;
  logic [TAPS-1:0]     cnt;
  code_t               codes [N_CONS];
  logic [N_CONS-1:0]   tap_pulse;
  logic                ext_rise;
  logic                tick_q;
  logic                clkout_q;

  psc_base #(.DIV(DIV), .CNT_W(TAPS)) u_base (
    .clk_i, .rst_ni, .base_tick_o(base_tick), .cnt_o(cnt)
  );

  assign codes[C_TIMER1] = timer1_code_i;
  assign codes[C_TIMER2] = timer2_code_i;
  assign codes[C_SHIFT]  = shift_code_i;
  assign codes[C_CONV]   = conv_code_i;
  assign codes[C_CLKOUT] = clkout_code_i;

  for (genvar g = 0; g < N_CONS; g++) begin : g_tap
    psc_tap #(.CNT_W(TAPS)) u_tap (
      .clk_i, .rst_ni, .base_tick_i(base_tick), .cnt_i(cnt),
      .code_i(codes[g]), .pulse_o(tap_pulse[g])
    );
  end

  psc_edge u_ext (.clk_i, .rst_ni, .async_i(timer2_ext_i), .rise_o(ext_rise));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q   <= 1'b0;
      clkout_q <= 1'b0;
    end else begin
      tick_q <= base_tick;
      if (base_tick && tap_pulse[C_CLKOUT] == 1'b0 && g_tap[C_CLKOUT].u_tap.legal
          && &(cnt | ~g_tap[C_CLKOUT].u_tap.mask))
        clkout_q <= ~clkout_q;
    end
  end

  assign instr_tick_o  = tick_q;
  assign timer1_tick_o = tap_pulse[C_TIMER1];
  assign timer2_tick_o = timer2_ext_sel_i ? ext_rise : tap_pulse[C_TIMER2];
  assign shift_tick_o  = tap_pulse[C_SHIFT];
  assign conv_tick_o   = tap_pulse[C_CONV];
  assign clkout_o      = clkout_q;

  a_r7_toggle_with_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clkout_q) |-> tap_pulse[C_CLKOUT]);
  a_r5_nested_taps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_pulse[C_CONV] && conv_code_i > timer1_code_i && timer1_code_i != 4'd0
      && 32'(conv_code_i) <= TAPS |-> tap_pulse[C_TIMER1]);
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !tick_q && !clkout_q && tap_pulse == '0);
endmodule

// File: tb/psc_top_test.sv
module psc_top_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] c_t1, c_t2, c_sh, c_cv, c_co;
  logic ext_sel = 1'b0, ext = 1'b0;
  logic instr_tick, t1, t2, sh, cv, co;
  int edge_n = 0;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  psc_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .timer1_code_i(c_t1), .timer2_code_i(c_t2), .shift_code_i(c_sh),
    .conv_code_i(c_cv), .clkout_code_i(c_co),
    .timer2_ext_sel_i(ext_sel), .timer2_ext_i(ext),
    .instr_tick_o(instr_tick), .timer1_tick_o(t1), .timer2_tick_o(t2),
    .shift_tick_o(sh), .conv_tick_o(cv), .clkout_o(co)
  );

  function automatic logic pick(int idx);
    case (idx)
      0: return instr_tick;
      1: return t1;
      2: return t2;
      3: return sh;
      4: return cv;
      default: return co;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(logic [3:0] a, logic [3:0] b, logic [3:0] s, logic [3:0] v,
                         logic [3:0] o, logic sel);
    @(negedge clk);
    rst_n = 1'b0;
    c_t1 = a; c_t2 = b; c_sh = s; c_cv = v; c_co = o; ext_sel = sel; ext = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edge_n = 0;
  endtask

  // returns edge index after which the signal is first seen high
  task automatic wait_high(int idx, int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (pick(idx)) begin at = edge_n; break; end
    end
  endtask

  task automatic period_check(string req, int idx, int per);
    int e1, e2;
    wait_high(idx, per + 20, e1);
    check(req, e1, per);
    @(negedge clk);
    check({req, " single"}, int'(pick(idx)), 0);
    wait_high(idx, per + 20, e2);
    check(req, e2 - e1, per);
  endtask

  task automatic t_reset;
    restart(4'd1, 4'd1, 4'd1, 4'd1, 4'd1, 1'b0);
    rst_n = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 ticks", int'(instr_tick | t1 | t2 | sh | cv), 0);
    check("R1 clkout", int'(co), 0);
    rst_n = 1'b1;
    edge_n = 0;
  endtask

  task automatic t_base;
    restart(4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0);
    period_check("R2 instr tick", 0, 6);
  endtask

  task automatic t_taps;
    restart(4'd1, 4'd3, 4'd12, 4'd5, 4'd0, 1'b0);
    period_check("R3 code1", 1, 12);
    restart(4'd1, 4'd3, 4'd12, 4'd5, 4'd0, 1'b0);
    period_check("R3 code3", 2, 48);
    restart(4'd1, 4'd3, 4'd12, 4'd5, 4'd0, 1'b0);
    period_check("R3 code5", 4, 192);
    restart(4'd1, 4'd3, 4'd12, 4'd5, 4'd0, 1'b0);
    period_check("R3 code12", 3, 24576);
  endtask

  task automatic t_illegal;
    int cnt = 0;
    restart(4'd0, 4'd13, 4'd14, 4'd15, 4'd0, 1'b0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      cnt += int'(t1) + int'(t2) + int'(sh) + int'(cv);
    end
    check("R4 illegal pulses", cnt, 0);
    check("R7 clkout idle on illegal", int'(co), 0);
  endtask

  task automatic t_coincide;
    int n_cv = 0, bad = 0, n_t1 = 0;
    restart(4'd1, 4'd0, 4'd0, 4'd4, 4'd0, 1'b0);
    for (int i = 0; i < 480; i++) begin
      @(negedge clk);
      if (cv) begin n_cv++; if (!t1) bad++; end
      if (t1) n_t1++;
    end
    check("R5 coarse without fine", bad, 0);
    check("R5 coarse count", n_cv, 5);
    check("R5 fine count", n_t1, 40);
  endtask

  task automatic t_clkout;
    int e_rise, e_fall;
    restart(4'd0, 4'd0, 4'd0, 4'd0, 4'd2, 1'b0);
    wait_high(5, 100, e_rise);
    check("R7 first rise", e_rise, 24);
    e_fall = -1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!co) begin e_fall = edge_n; break; end
    end
    check("R7 first fall", e_fall, 48);
  endtask

  task automatic t_ext;
    int n = 0;
    restart(4'd0, 4'd1, 4'd0, 4'd0, 4'd0, 1'b1);
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); ext = (i < 20); n += int'(t2);
      end
    end
    repeat (10) begin @(negedge clk); n += int'(t2); end
    check("R6 ext pulses", n, 5);
    restart(4'd0, 4'd1, 4'd0, 4'd0, 4'd0, 1'b0);
    period_check("R6 internal when deselected", 2, 12);
  endtask

  initial begin
    c_t1 = 0; c_t2 = 0; c_sh = 0; c_cv = 0; c_co = 0;
    t_reset();
    t_base();
    t_taps();
    t_illegal();
    t_coincide();
    t_clkout();
    t_ext();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule